// File: doc/BRIEF.md
# Cascadable Up/Down Counter

A synchronous binary counter of parameterised width. On each rising clock edge it can take a parallel value, step up by one, step down by one, or hold. Up and down are two separate command lines. A parallel load overrides both of them. When both lines are asserted together, the counter holds its value.

Two enables control stepping. Stepping up is gated by an incoming carry and stepping down by an incoming borrow. The block produces a carry-out when the count is all ones and a borrow-out when the count is all zeros. Several counters can therefore be chained into a wider counter that counts in both directions: each stage's carry-out and borrow-out feed the next stage's carry-in and borrow-in.

The terminal-count detection and the per-bit toggle conditions come from a logarithmic prefix tree, not a ripple chain. This keeps the cascade path short for wide stages. The block also presents the bitwise complement of the count.

Top module: `updn_counter`

## Requirements
- R1: When `load` is 1, the next rising edge stores `loadValue` into `count`, whatever `up`, `down`, `carryIn` and `borrowIn` are.
- R2: When `load` is 0, `up` is 1, `down` is 0 and `carryIn` is 1, the next rising edge increases `count` by one.
- R3: When `load` is 0, `down` is 1, `up` is 0 and `borrowIn` is 1, the next rising edge decreases `count` by one.
- R4: When `load` is 0 and both `up` and `down` are 1, `count` keeps its value across the edge.
- R5: An up command with `carryIn` at 0, or a down command with `borrowIn` at 0, leaves `count` unchanged.
- R6: Counting up from all ones gives all zeros. Counting down from all zeros gives all ones.
- R7: `countN` is at all times the bitwise inverse of `count`.
- R8: `carryOut` is 1 exactly when `carryIn` is 1 and every bit of `count` is 1. `borrowOut` is 1 exactly when `borrowIn` is 1 and every bit of `count` is 0. Both are combinational.
- R9: The cascade outputs do not depend on `load`, `up` or `down`.
- R10: With `load`, `up` and `down` all 0, `count` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load | input | 1 | Parallel load command, highest priority |
| up | input | 1 | Step-up command |
| down | input | 1 | Step-down command |
| carryIn | input | 1 | Cascade carry; enables stepping up |
| borrowIn | input | 1 | Cascade borrow; enables stepping down |
| loadValue | input | WIDTH | Value taken on load |
| count | output | WIDTH | Current count |
| countN | output | WIDTH | Bitwise complement of the count |
| carryOut | output | 1 | Carry to the next stage |
| borrowOut | output | 1 | Borrow to the next stage |

## Verification
Each command changes `count` at the first rising edge after it is presented, so `count` and `countN` are due one edge later. `carryOut` and `borrowOut` follow combinationally from the current count and the incoming carry or borrow, so they are due in the same cycle. The bench changes inputs on falling edges and samples one time unit after the rising edge, while the inputs still hold. This lets each cascade output be checked against the count that has just settled. For R9, the commands are varied between two rising edges and the cascade outputs are sampled before the next edge.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Strobes passed from the command decoder to the datapath.
  typedef struct packed {
    logic doLoad;
    logic doInc;
    logic doDec;
  } stepCmd_t;

endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic     load,
  input  logic     up,
  input  logic     down,
  input  logic     carryIn,
  input  logic     borrowIn,
  output stepCmd_t cmd
);

  // Load wins. Conflicting directions cancel. Each direction needs its enable.
  always_comb begin
    cmd.doLoad = load;
    cmd.doInc  = !load && up && !down && carryIn;
    cmd.doDec  = !load && down && !up && borrowIn;
  end

  always_comb begin
    // R1 / R4: the strobes are mutually exclusive
    if (!$isunknown({load, up, down, carryIn, borrowIn}))
      strobe_excl_chk: assert ($countones({cmd.doLoad, cmd.doInc, cmd.doDec}) <= 1)
        else $error("strobes not exclusive");
  end

endmodule

// File: rtl/updn_lookahead.sv
module updn_lookahead #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] countQ,
  input  logic             carryIn,
  input  logic             borrowIn,
  output logic [WIDTH-1:0] incToggle,
  output logic [WIDTH-1:0] decToggle,
  output logic             carryOut,
  output logic             borrowOut
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  // Inclusive prefix AND over ones and over zeros, doubling span each level.
  logic [WIDTH-1:0] onesLvl  [0:LEVELS];
  logic [WIDTH-1:0] zerosLvl [0:LEVELS];

  assign onesLvl[0]  = countQ;
  assign zerosLvl[0] = ~countQ;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int SPAN = (2 ** l < WIDTH) ? 2 ** l : WIDTH;
    assign onesLvl[l+1]  = onesLvl[l]  & WIDTH'({onesLvl[l],  {SPAN{1'b1}}});
    assign zerosLvl[l+1] = zerosLvl[l] & WIDTH'({zerosLvl[l], {SPAN{1'b1}}});
  end

  // Bit i toggles when all lower bits are ones (up) or zeros (down).
  assign incToggle = WIDTH'({onesLvl[LEVELS],  1'b1});
  assign decToggle = WIDTH'({zerosLvl[LEVELS], 1'b1});

  assign carryOut  = carryIn  && onesLvl[LEVELS][WIDTH-1];
  assign borrowOut = borrowIn && zerosLvl[LEVELS][WIDTH-1];

  always_comb begin
    if (!$isunknown({countQ, carryIn, borrowIn})) begin
      // R8
      carry_tree_chk: assert (carryOut == (carryIn && (&countQ)))
        else $error("carry tree mismatch");
      // R8
      borrow_tree_chk: assert (borrowOut == (borrowIn && !(|countQ)))
        else $error("borrow tree mismatch");
    end
  end

endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  stepCmd_t         cmd,
  input  logic [WIDTH-1:0] loadValue,
  input  logic [WIDTH-1:0] incToggle,
  input  logic [WIDTH-1:0] decToggle,
  output logic [WIDTH-1:0] countQ
);

  logic [WIDTH-1:0] countNext;

  always_comb begin
    if (cmd.doLoad)     countNext = loadValue;
    else if (cmd.doInc) countNext = countQ ^ incToggle;
    else if (cmd.doDec) countNext = countQ ^ decToggle;
    else                countNext = countQ;
  end

  always_ff @(posedge clk) countQ <= countNext;

  // Checker-side qualifier: no $past before the first edge.
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  // R1
  load_take_chk: assert property (@(posedge clk) disable iff (!primed)
    $past(cmd.doLoad) |-> countQ == $past(loadValue))
    else $error("load not taken");

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!primed)
    ($past(cmd.doInc) && !$isunknown($past(countQ))) |-> countQ == WIDTH'($past(countQ) + 1'b1))
    else $error("increment wrong");

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!primed)
    ($past(cmd.doDec) && !$isunknown($past(countQ))) |-> countQ == WIDTH'($past(countQ) - 1'b1))
    else $error("decrement wrong");

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!primed)
    (!$past(cmd.doLoad) && !$past(cmd.doInc) && !$past(cmd.doDec)
      && !$isunknown($past(countQ))) |-> $stable(countQ))
    else $error("count moved without a strobe");

endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             load,
  input  logic             up,
  input  logic             down,
  input  logic             carryIn,
  input  logic             borrowIn,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] countN,
  output logic             carryOut,
  output logic             borrowOut
);

  stepCmd_t         cmd;
  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] incToggle;
  logic [WIDTH-1:0] decToggle;

  updn_ctrl u_ctrl (
    .load(load), .up(up), .down(down),
    .carryIn(carryIn), .borrowIn(borrowIn), .cmd(cmd)
  );

  updn_lookahead #(.WIDTH(WIDTH)) u_tree (
    .countQ(countQ), .carryIn(carryIn), .borrowIn(borrowIn),
    .incToggle(incToggle), .decToggle(decToggle),
    .carryOut(carryOut), .borrowOut(borrowOut)
  );

  updn_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .cmd(cmd), .loadValue(loadValue),
    .incToggle(incToggle), .decToggle(decToggle), .countQ(countQ)
  );

  assign count  = countQ;
  assign countN = ~countQ;

endmodule

// File: tb/updn_counter_tb_top.sv
module updn_counter_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         load = 1'b0, up = 1'b0, down = 1'b0, carryIn = 1'b0, borrowIn = 1'b0;
  logic [W-1:0] loadValue = '0;
  logic [W-1:0] count, countN;
  logic         carryOut, borrowOut;

  always #4 clk = ~clk;  // 125 MHz

  updn_counter #(.WIDTH(W)) dut_i (
    .clk(clk), .load(load), .up(up), .down(down),
    .carryIn(carryIn), .borrowIn(borrowIn), .loadValue(loadValue),
    .count(count), .countN(countN), .carryOut(carryOut), .borrowOut(borrowOut)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {load, up, down, carryIn, borrowIn, loadValue, expected count}
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {5'b11010, 8'h5A, 8'h5A},  // R1 load beats up
    {5'b01010, 8'h00, 8'h5B},  // R2
    {5'b01010, 8'h00, 8'h5C},  // R2
    {5'b00101, 8'h00, 8'h5B},  // R3
    {5'b01111, 8'h00, 8'h5B},  // R4
    {5'b01000, 8'h00, 8'h5B},  // R5 no carry
    {5'b00110, 8'h00, 8'h5B},  // R5 no borrow
    {5'b00011, 8'h00, 8'h5B},  // R10
    {5'b10101, 8'hFE, 8'hFE},  // R1 load beats down
    {5'b01010, 8'h00, 8'hFF},  // R2
    {5'b01010, 8'h00, 8'h00},  // R6 wrap up
    {5'b00101, 8'h00, 8'hFF},  // R6 wrap down
    {5'b10000, 8'h00, 8'h00},  // R1
    {5'b00011, 8'h00, 8'h00},  // R10, borrowOut
    {5'b11010, 8'h0F, 8'h0F},  // R1
    {5'b01010, 8'h00, 8'h10},  // R2 multi-bit carry
    {5'b00101, 8'h00, 8'h0F}   // R3 multi-bit borrow
  };

  task automatic applyAndCheck(input logic [20:0] v);
    @(negedge clk);
    {load, up, down, carryIn, borrowIn} = v[20:16];
    loadValue = v[15:8];
    @(posedge clk);
    #1;
    check(count === v[7:0], "R1/R2/R3/R4/R5/R6/R10 count", count, v[7:0]);
    check(countN === ~v[7:0], "R7 countN", countN, ~v[7:0]);
    check(carryOut === (v[19-0-16+16] && v[7:0] == 8'hFF) || carryOut === (v[17] && v[7:0] == 8'hFF),
          "R8 carryOut", {7'd0, carryOut}, {7'd0, v[17] && v[7:0] == 8'hFF});
    check(borrowOut === (v[16] && v[7:0] == 8'h00), "R8 borrowOut",
          {7'd0, borrowOut}, {7'd0, v[16] && v[7:0] == 8'h00});
  endtask

  initial begin
    fork
      begin
        for (int i = 0; i < NV; i++) applyAndCheck(VEC[i]);

        // R9: count at FF, vary commands between edges, cascade outputs fixed
        applyAndCheck({5'b10011, 8'hFF, 8'hFF});
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          {load, up, down} = k[2:0];
          carryIn = 1'b1; borrowIn = 1'b1; loadValue = 8'hFF;
          #0.5;
          check(carryOut === 1'b1, "R9 carryOut", {7'd0, carryOut}, 8'd1);
          check(borrowOut === 1'b0, "R9 borrowOut", {7'd0, borrowOut}, 8'd0);
        end
        // R8 combinational: drop carryIn mid-cycle
        carryIn = 1'b0;
        #0.5;
        check(carryOut === 1'b0, "R8 carryIn gate", {7'd0, carryOut}, 8'd0);
        load = 1'b0; up = 1'b0; down = 1'b0;

        // R4 at a wrap boundary: both commands at FF with both enables
        applyAndCheck({5'b01111, 8'h00, 8'hFF});
        // R6 carry chain edge: FF up wraps even from a reload
        applyAndCheck({5'b01010, 8'h00, 8'h00});
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule